// File: doc/BRIEF.md
# Arithmetic Right Shift Unit with Carry Flags

This block is a 64-bit integer execution unit that performs signed (arithmetic) right shifts. It offers a word form, which first sign-extends the low 32 bits of the source, and a doubleword form, which works on all 64 bits. The shift count comes either from the low bits of a register operand or from an immediate field. Along with the shifted result, the unit produces:

- a carry flag, set when a negative value loses at least one 1 bit off the bottom;
- an optional second carry flag, used for 32-bit mode;
- an optional condition-field update.

An accepted operation is captured on the clock edge where `in_valid` is high. The registered result appears on the next cycle, with `out_valid` high for that single cycle. A two-state machine sequences this. `ST_IDLE` moves to `ST_DONE` when `in_valid` is sampled high. `ST_DONE` stays in `ST_DONE` while operations keep arriving back to back, and returns to `ST_IDLE` when none arrives.

Top module: `sra_carry_unit`

## Requirements
- R1: In word form (`dword`=0), the low 32 bits of `src` are sign-extended to 64 bits and then shifted right arithmetically. The count is `sh_reg[4:0]` (register form, when `sh_reg[5]`=0) or `sh_imm[4:0]` (immediate form).
- R2: In doubleword form (`dword`=1), the full 64-bit `src` is shifted right arithmetically. The count is `sh_reg[5:0]` (register form, when `sh_reg[6]`=0) or `sh_imm[5:0]` (immediate form).
- R3: `carry` is 1 only when the 64-bit result is negative and at least one bit shifted out was 1. Otherwise `carry` is 0.
- R4: A count of zero returns the sign-extended word (word form) or the unchanged source (doubleword form), with `carry`=0.
- R5: In register form, `sh_reg[5]` (word) or `sh_reg[6]` (doubleword) marks an out-of-range count. In that case every result bit equals the sign bit of the extended operand, and `carry` equals that sign bit. In word form, `sh_reg[6]` is ignored.
- R6: Immediate forms (`use_imm`=1) are never out of range, and `sh_reg` has no effect on them. In word form, `sh_imm[5]` is ignored.
- R7: When `v3_mode`=1, `carry32` is written with the same value as `carry` and `carry32_we`=1 on that result.
- R8: When `v3_mode`=0, `carry32` keeps its previous value and `carry32_we`=0 on that result.
- R9: When `rec`=1, `cr_field` is written and `cr_we`=1. Its bits are [3]=result<0, [2]=result>0, [1]=result==0 (signed, exactly one of these set) and [0]=`so_in`. When `rec`=0, `cr_we`=0 and `cr_field` keeps its value.
- R10: Outputs are registered on the edge that samples `in_valid`=1, and `out_valid` is high for exactly the following cycle. Back-to-back operations produce one result per cycle. `result` and `carry` hold their values between operations, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 64 | Source operand |
| sh_reg | input | 7 | Low bits of the register shift operand |
| sh_imm | input | 6 | Immediate shift count |
| use_imm | input | 1 | 1 = immediate form, 0 = register form |
| dword | input | 1 | 1 = doubleword form, 0 = word form |
| rec | input | 1 | Record: update the condition field |
| v3_mode | input | 1 | Enables the 32-bit-mode carry flag |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Shifted, sign-extended result |
| carry | output | 1 | Carry flag |
| carry32 | output | 1 | 32-bit-mode carry flag |
| carry32_we | output | 1 | `carry32` written by the last result |
| cr_field | output | 4 | Condition field {lt, gt, eq, so} |
| cr_we | output | 1 | `cr_field` written by the last result |

## Verification
The assertions check the following on every cycle:

- `out_valid` only ever follows an accepted input by one cycle.
- A set `carry` always comes with a negative `result`.
- `carry32` equals `carry` whenever it is written, and does not move when it is not written.
- A written condition field has exactly one of its three relation bits set.

Only the bench scenarios can show the arithmetic itself. This covers the exact shifted value and carry for chosen operands, and the zero-count and out-of-range boundaries. It also covers the field bits that must be ignored (`sh_reg[6]` in word form, `sh_imm[5]` in word form, `sh_reg` in immediate form) and the holding of `cr_field` when `rec` is low.

// File: rtl/sra_pkg.sv
package sra_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } sra_state_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_field_t;

endpackage

// File: rtl/sra_amount_sel.sv
module sra_amount_sel #(
    parameter int XLEN = 64,
    localparam int AW  = $clog2(XLEN)
) (
    input  logic [AW:0]   sh_reg,
    input  logic [AW-1:0] sh_imm,
    input  logic          use_imm,
    input  logic          dword,
    output logic [AW-1:0] amt,
    output logic          oor
);

    always_comb begin
        unique case ({use_imm, dword})
            2'b00: begin
                amt = {1'b0, sh_reg[AW-2:0]};
                oor = sh_reg[AW-1];
            end
            2'b01: begin
                amt = sh_reg[AW-1:0];
                oor = sh_reg[AW];
            end
            2'b10: begin
                amt = {1'b0, sh_imm[AW-2:0]};
                oor = 1'b0;
            end
            default: begin
                amt = sh_imm;
                oor = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sra_shift_core.sv
module sra_shift_core #(
    parameter int XLEN = 64,
    localparam int AW   = $clog2(XLEN),
    localparam int HALF = XLEN / 2
) (
    input  logic [XLEN-1:0] src,
    input  logic            dword,
    input  logic [AW-1:0]   amt,
    input  logic            oor,
    output logic [XLEN-1:0] res,
    output logic            carry
);

    logic [XLEN-1:0] op;
    logic [XLEN-1:0] lost_bits;
    logic            sign;

    assign op   = dword ? src : {{HALF{src[HALF-1]}}, src[HALF-1:0]};
    assign sign = op[XLEN-1];

    for (genvar i = 0; i < XLEN; i++) begin : g_lost
        localparam logic [AW-1:0] IDX = AW'(i);
        assign lost_bits[i] = (IDX < amt) & op[i];
    end

    always_comb begin
        if (oor) begin
            res   = {XLEN{sign}};
            carry = sign;
        end else begin
            res   = $unsigned($signed(op) >>> amt);
            carry = sign & (|lost_bits);
        end
    end

endmodule

// File: rtl/sra_cond_gen.sv
module sra_cond_gen
    import sra_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] res,
    input  logic            so_in,
    output cr_field_t       field
);

    always_comb begin
        field.lt = res[XLEN-1];
        field.eq = (res == '0);
        field.gt = ~res[XLEN-1] & (res != '0);
        field.so = so_in;
    end

endmodule

// File: rtl/sra_carry_unit.sv
module sra_carry_unit
    import sra_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int AW  = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] src,
    input  logic [AW:0]     sh_reg,
    input  logic [AW-1:0]   sh_imm,
    input  logic            use_imm,
    input  logic            dword,
    input  logic            rec,
    input  logic            v3_mode,
    input  logic            so_in,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            carry,
    output logic            carry32,
    output logic            carry32_we,
    output logic [3:0]      cr_field,
    output logic            cr_we
);

    sra_state_e      state_q, state_d;
    logic [AW-1:0]   amt;
    logic            oor;
    logic [XLEN-1:0] shift_res;
    logic            shift_carry;
    cr_field_t       cr_next;

    sra_amount_sel #(.XLEN(XLEN)) u_amount (
        .sh_reg  (sh_reg),
        .sh_imm  (sh_imm),
        .use_imm (use_imm),
        .dword   (dword),
        .amt     (amt),
        .oor     (oor)
    );

    sra_shift_core #(.XLEN(XLEN)) u_core (
        .src   (src),
        .dword (dword),
        .amt   (amt),
        .oor   (oor),
        .res   (shift_res),
        .carry (shift_carry)
    );

    sra_cond_gen #(.XLEN(XLEN)) u_cond (
        .res   (shift_res),
        .so_in (so_in),
        .field (cr_next)
    );

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q == ST_DONE);

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            carry      <= 1'b0;
            carry32    <= 1'b0;
            carry32_we <= 1'b0;
            cr_field   <= '0;
            cr_we      <= 1'b0;
        end else if (in_valid) begin
            result     <= shift_res;
            carry      <= shift_carry;
            carry32_we <= v3_mode;
            cr_we      <= rec;
            if (v3_mode) carry32  <= shift_carry;
            if (rec)     cr_field <= cr_next;
        end else begin
            carry32_we <= 1'b0;
            cr_we      <= 1'b0;
        end
    end

    // Checks
    assert_valid_follows_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid))
        else $error("out_valid without prior input");

    assert_carry_needs_negative_R3: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> result[XLEN-1])
        else $error("carry set on non-negative result");

    assert_carry32_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && carry32_we) |-> (carry32 == carry))
        else $error("carry32 differs from carry");

    assert_carry32_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !carry32_we |=> (!carry32_we |-> $stable(carry32)))
        else $error("carry32 moved without write");

    assert_cr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cr_we) |-> ($countones(cr_field[3:1]) == 1))
        else $error("condition field not one-hot");

endmodule

// File: tb/sra_carry_unit_tb.sv
module sra_carry_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src = '0;
    logic [6:0]  sh_reg = '0;
    logic [5:0]  sh_imm = '0;
    logic        use_imm = 1'b0, dword = 1'b0, rec = 1'b0, v3_mode = 1'b0, so_in = 1'b0;
    logic        out_valid, carry, carry32, carry32_we, cr_we;
    logic [63:0] result;
    logic [3:0]  cr_field;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    sra_carry_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .sh_reg(sh_reg),
        .sh_imm(sh_imm), .use_imm(use_imm), .dword(dword), .rec(rec), .v3_mode(v3_mode),
        .so_in(so_in), .out_valid(out_valid), .result(result), .carry(carry),
        .carry32(carry32), .carry32_we(carry32_we), .cr_field(cr_field), .cr_we(cr_we)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent reference: bit-serial arithmetic shift
    task automatic model(input logic [63:0] s, input logic [6:0] sr, input logic [5:0] si,
                         input bit imm, input bit dw,
                         output logic [63:0] r, output logic c);
        logic [63:0] v;
        int  n;
        bit  big, lost;
        v = dw ? s : {{32{s[31]}}, s[31:0]};
        if (imm) begin n = dw ? int'(si) : int'(si[4:0]); big = 0; end
        else begin n = dw ? int'(sr[5:0]) : int'(sr[4:0]); big = dw ? sr[6] : sr[5]; end
        if (big) begin r = {64{v[63]}}; c = v[63]; end
        else begin
            lost = 0; r = v;
            for (int k = 0; k < n; k++) begin
                lost = lost | r[0];
                r = {r[63], r[63:1]};
            end
            c = v[63] & lost;
        end
    endtask

    // Drive one op at negedge; outputs visible at following negedge
    task automatic issue(logic [63:0] s, logic [6:0] sr, logic [5:0] si, bit imm, bit dw,
                         bit rc, bit v3, bit so);
        src = s; sh_reg = sr; sh_imm = si; use_imm = imm; dword = dw;
        rec = rc; v3_mode = v3; so_in = so; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic op_check(string tag, logic [63:0] s, logic [6:0] sr, logic [5:0] si,
                            bit imm, bit dw);
        logic [63:0] er; logic ec;
        model(s, sr, si, imm, dw, er, ec);
        issue(s, sr, si, imm, dw, 0, 0, 0);
        chk({tag, " valid"}, 64'(out_valid), 64'd1);
        chk({tag, " result"}, result, er);
        chk({tag, " carry"}, 64'(carry), 64'(ec));
    endtask

    task automatic t_reset();
        chk("R10 reset valid", 64'(out_valid), 0);
        chk("R10 reset result", result, 0);
        chk("R10 reset flags", {58'd0, carry, carry32, carry32_we, cr_we, 2'b0}, 0);
        chk("R10 reset cr", 64'(cr_field), 0);
    endtask

    task automatic t_word_reg();
        op_check("R1 word neg lost", 64'hDEAD_BEEF_8000_0013, 7'd4, 6'd0, 0, 0);
        op_check("R1 word pos", 64'h0000_0000_7654_3210, 7'd12, 6'd0, 0, 0);
        op_check("R3 word neg nolost", 64'h0000_0000_FFFF_FF00, 7'd8, 6'd0, 0, 0);
        op_check("R3 word neg max", 64'h0000_0000_8000_0001, 7'd31, 6'd0, 0, 0);
        chk("R3 carry set on lost one", 64'(carry), 1);
    endtask

    task automatic t_dword_reg();
        op_check("R2 dword neg", 64'h8000_0000_0000_0003, 7'd1, 6'd0, 0, 1);
        chk("R2 dword carry", 64'(carry), 1);
        op_check("R2 dword 63", 64'hF000_0000_0000_0000, 7'd63, 6'd0, 0, 1);
        op_check("R3 dword pos lost", 64'h7FFF_FFFF_FFFF_FFFF, 7'd40, 6'd0, 0, 1);
        chk("R3 pos no carry", 64'(carry), 0);
    endtask

    task automatic t_zero();
        op_check("R4 word zero", 64'h1234_5678_8765_4321, 7'd0, 6'd0, 0, 0);
        chk("R4 word zero ext", result, 64'hFFFF_FFFF_8765_4321);
        op_check("R4 dword zero", 64'h8123_4567_89AB_CDEF, 7'd0, 6'd0, 0, 1);
        chk("R4 dword unchanged", result, 64'h8123_4567_89AB_CDEF);
        op_check("R4 imm zero", 64'hFFFF_FFFF_FFFF_FFFF, 7'd0, 6'd0, 1, 1);
        chk("R4 carry zero", 64'(carry), 0);
    endtask

    task automatic t_oor();
        op_check("R5 word oor neg", 64'h0000_0000_8000_0000, 7'd32, 6'd0, 0, 0);
        chk("R5 word oor all ones", result, '1);
        op_check("R5 word oor pos", 64'hFFFF_FFFF_7FFF_FFFF, 7'd33, 6'd0, 0, 0);
        chk("R5 word oor zero", result, 0);
        op_check("R5 word bit6 ignored", 64'h0000_0000_F000_0000, 7'h44, 6'd0, 0, 0);
        chk("R5 word bit6 ignored val", result, 64'hFFFF_FFFF_FF00_0000);
        op_check("R5 dword oor", 64'h8000_0000_0000_0000, 7'd64, 6'd0, 0, 1);
        chk("R5 dword oor carry", 64'(carry), 1);
    endtask

    task automatic t_imm();
        op_check("R6 imm word", 64'h0000_0000_8000_00FF, 7'h7F, 6'd4, 1, 0);
        op_check("R6 imm word bit5 ignored", 64'h0000_0000_8000_00FF, 7'h7F, 6'd36, 1, 0);
        chk("R6 bit5 ignored val", result, 64'hFFFF_FFFF_F800_000F);
        op_check("R6 imm dword", 64'hC000_0000_0000_0001, 7'h7F, 6'd62, 1, 1);
    endtask

    task automatic t_v3();
        issue(64'h0000_0000_8000_0001, 7'd1, 6'd0, 0, 0, 0, 1, 0);
        chk("R7 carry32 we", 64'(carry32_we), 1);
        chk("R7 carry32 value", 64'(carry32), 1);
        issue(64'h0000_0000_0000_0001, 7'd1, 6'd0, 0, 0, 0, 0, 0);
        chk("R8 carry32 we off", 64'(carry32_we), 0);
        chk("R8 carry32 held", 64'(carry32), 1);
        chk("R8 carry cleared", 64'(carry), 0);
        issue(64'h0000_0000_0000_0001, 7'd1, 6'd0, 0, 0, 0, 1, 0);
        chk("R7 carry32 cleared", 64'(carry32), 0);
    endtask

    task automatic t_record();
        issue(64'h8000_0000_0000_0000, 7'd4, 6'd0, 0, 1, 1, 0, 1);
        chk("R9 lt", 64'(cr_field), 64'b1001);
        chk("R9 we", 64'(cr_we), 1);
        issue(64'h0000_0000_0000_0100, 7'd4, 6'd0, 0, 1, 1, 0, 0);
        chk("R9 gt", 64'(cr_field), 64'b0100);
        issue(64'h0000_0000_0000_000F, 7'd4, 6'd0, 0, 1, 1, 0, 0);
        chk("R9 eq", 64'(cr_field), 64'b0010);
        issue(64'h8000_0000_0000_0000, 7'd0, 6'd0, 0, 1, 0, 0, 1);
        chk("R9 no rec we", 64'(cr_we), 0);
        chk("R9 no rec held", 64'(cr_field), 64'b0010);
    endtask

    task automatic t_timing();
        logic [63:0] e1, e2; logic c1, c2;
        model(64'h0000_0000_F000_0000, 7'd4, 6'd0, 0, 0, e1, c1);
        model(64'h0000_0000_0000_0F00, 7'd4, 6'd0, 0, 0, e2, c2);
        src = 64'h0000_0000_F000_0000; sh_reg = 7'd4; use_imm = 0; dword = 0;
        rec = 0; v3_mode = 0; in_valid = 1;
        @(negedge clk);
        chk("R10 b2b first valid", 64'(out_valid), 1);
        chk("R10 b2b first", result, e1);
        src = 64'h0000_0000_0000_0F00;
        @(negedge clk);
        in_valid = 0;
        chk("R10 b2b second", result, e2);
        chk("R10 b2b second valid", 64'(out_valid), 1);
        src = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        chk("R10 valid single", 64'(out_valid), 0);
        chk("R10 result held", result, e2);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_word_reg();
        t_dword_reg();
        t_zero();
        t_oor();
        t_imm();
        t_v3();
        t_record();
        t_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule